// File: doc/BRIEF.md
# Delayed Write Completion Handler

This block sits in a bus bridge and carries one delayed write from the near-side initiator to the far bus. When the initiator first presents a write, the block latches its address, command, byte enables and data, answers with a retry, and starts issuing the write on the far side. It keeps reissuing the same write for as long as the far target answers with a retry. The far target's final termination is then held until the initiator repeats the identical request. At that point the block maps the stored termination onto the answer the initiator gets, and releases the entry.

If every attempt is retried until the attempt limit runs out, the block drops the entry. It then raises a one-cycle system-error pulse, which is gated by an enable bit and by a separate mask bit for delayed-write non-delivery. Three sticky status flags record a target abort received on the far side, a target abort signaled to the initiator, and a signaled system error. Each flag is cleared by a write-one pulse.

Top module: `dwr_handler`

## Requirements
- R1: Every cycle in which `ini_req` is high is answered one cycle later with `ini_rsp_vld` high for one cycle. A request seen while idle is latched and answered with retry (code 0). The first far attempt (`fw_start` high, latched fields on `fw_*`) follows in the cycle after the request.
- R2: Until the far result is known, every request, matching or not, is answered with retry (0). Only one far attempt is outstanding at a time: `fw_start` never stays high for two cycles in a row.
- R3: A far termination of retry (code 1) causes another attempt in the following cycle, with the same address, command, byte enables and data.
- R4: A far termination of normal (code 0) or disconnect (code 2) is reported to the matching repeated request as disconnect-with-first-data (code 2) when `ini_multi` is high, and as complete (code 1) otherwise. The entry is then released and the block is idle.
- R5: A far target abort (code 3) sets `sts_rx_tabort` on the cycle after it arrives. The matching repeated request is answered with target abort (code 3), and `sts_sig_tabort` is set together with that answer.
- R6: A request counts as matching only when the address, command, byte enables and data all equal the latched values. A non-matching request while a result is held gets retry (0), and the held result stays available.
- R7: When the attempt limit is reached with every attempt retried, the entry is dropped and no further attempt starts. `serr_o` pulses in the cycle of the last retry only if `cfg_serr_en` is 1 and `cfg_dwnd_dis` is 0. In that case `sts_sig_serr` is set on the following cycle.
- R8: The attempt limit is 2^LOG_DFLT when `cfg_lim_max` is 0, and 2^LOG_MAX when it is 1.
- R9: Status flags are sticky. A 1 on `sts_clr` bit 0, 1 or 2 clears `sts_rx_tabort`, `sts_sig_tabort` or `sts_sig_serr` respectively. A set in the same cycle wins over the clear.
- R10: After reset the block is idle: `fw_start`, `ini_rsp_vld`, `serr_o` and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_req | input | 1 | Initiator presents a write this cycle |
| ini_addr | input | AW | Write address |
| ini_cmd | input | CW | Write command |
| ini_be | input | DW/8 | Byte enables |
| ini_data | input | DW | Write data |
| ini_multi | input | 1 | Initiator asked for more than one data phase |
| ini_rsp_vld | output | 1 | Answer to the previous cycle's request |
| ini_rsp | output | 2 | 0 retry, 1 complete, 2 disconnect with first data, 3 target abort |
| fw_start | output | 1 | Start a far-side write attempt |
| fw_addr | output | AW | Latched address |
| fw_cmd | output | CW | Latched command |
| fw_be | output | DW/8 | Latched byte enables |
| fw_data | output | DW | Latched data |
| fw_term_vld | input | 1 | Far attempt terminated this cycle |
| fw_term | input | 2 | 0 normal, 1 retry, 2 disconnect, 3 target abort |
| cfg_serr_en | input | 1 | System error enable |
| cfg_dwnd_dis | input | 1 | Masks system error for delayed-write non-delivery |
| cfg_lim_max | input | 1 | Selects the maximum attempt limit |
| sts_clr | input | 3 | Write-one-to-clear pulses for the status flags |
| serr_o | output | 1 | System error pulse |
| sts_rx_tabort | output | 1 | Target abort received on far side |
| sts_sig_tabort | output | 1 | Target abort signaled to initiator |
| sts_sig_serr | output | 1 | System error signaled |

## Verification
If the state is stuck or wrong, the next repeated request shows it within one cycle. The block either keeps answering retry after the far side has finished, or gives a final answer too early or to a request that does not match. A miscounted attempt counter shows as an extra or missing `fw_start` around the limit, and as a misplaced `serr_o` pulse. Corrupted latched fields show on `fw_*` at the next attempt, and a bad stored termination shows in the final answer code.

// File: rtl/dwr_handler.sv
module dwr_handler #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 4,
  parameter int LOG_DFLT = 24,
  parameter int LOG_MAX  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ini_req,
  input  logic [AW-1:0]   ini_addr,
  input  logic [CW-1:0]   ini_cmd,
  input  logic [DW/8-1:0] ini_be,
  input  logic [DW-1:0]   ini_data,
  input  logic            ini_multi,
  output logic            ini_rsp_vld,
  output logic [1:0]      ini_rsp,
  output logic            fw_start,
  output logic [AW-1:0]   fw_addr,
  output logic [CW-1:0]   fw_cmd,
  output logic [DW/8-1:0] fw_be,
  output logic [DW-1:0]   fw_data,
  input  logic            fw_term_vld,
  input  logic [1:0]      fw_term,
  input  logic            cfg_serr_en,
  input  logic            cfg_dwnd_dis,
  input  logic            cfg_lim_max,
  input  logic [2:0]      sts_clr,
  output logic            serr_o,
  output logic            sts_rx_tabort,
  output logic            sts_sig_tabort,
  output logic            sts_sig_serr
);
  localparam logic [LOG_MAX-1:0] M1_DFLT = LOG_MAX'((64'd1 << LOG_DFLT) - 64'd1);
  localparam logic [LOG_MAX-1:0] M1_MAX  = {LOG_MAX{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;
  st_t              st;
  logic [LOG_MAX-1:0] tries;
  logic [1:0]       res;

  wire match   = ini_req && ini_addr == fw_addr && ini_cmd == fw_cmd &&
                 ini_be == fw_be && ini_data == fw_data;
  wire term_ok = st == S_WAIT && fw_term_vld;
  wire last    = tries == (cfg_lim_max ? M1_MAX : M1_DFLT);
  wire give_up = term_ok && fw_term == 2'd1 && last;
  wire deliver = st == S_DONE && match;
  wire [1:0] mapped = (res == 2'd3) ? 2'd3 : (ini_multi ? 2'd2 : 2'd1);

  assign fw_start = st == S_ISSUE;
  assign serr_o   = give_up && cfg_serr_en && !cfg_dwnd_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tries   <= '0;
      res     <= 2'd0;
      fw_addr <= '0;
      fw_cmd  <= '0;
      fw_be   <= '0;
      fw_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (ini_req) begin
          fw_addr <= ini_addr;
          fw_cmd  <= ini_cmd;
          fw_be   <= ini_be;
          fw_data <= ini_data;
          tries   <= '0;
          st      <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (fw_term_vld) begin
          if (fw_term == 2'd1) begin
            if (last) st <= S_IDLE;
            else begin
              tries <= tries + 1'b1;
              st    <= S_ISSUE;
            end
          end else begin
            res <= fw_term;
            st  <= S_DONE;
          end
        end
        S_DONE: if (match) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ini_rsp_vld    <= 1'b0;
      ini_rsp        <= 2'd0;
      sts_rx_tabort  <= 1'b0;
      sts_sig_tabort <= 1'b0;
      sts_sig_serr   <= 1'b0;
    end else begin
      ini_rsp_vld    <= ini_req;
      ini_rsp        <= deliver ? mapped : 2'd0;
      sts_rx_tabort  <= (sts_rx_tabort  & ~sts_clr[0]) | (term_ok && fw_term == 2'd3);
      sts_sig_tabort <= (sts_sig_tabort & ~sts_clr[1]) | (deliver && res == 2'd3);
      sts_sig_serr   <= (sts_sig_serr   & ~sts_clr[2]) | serr_o;
    end
  end
endmodule

// File: rtl/dwr_handler_chk.sv
module dwr_handler_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ini_req,
  input logic          ini_rsp_vld,
  input logic [1:0]    ini_rsp,
  input logic          fw_start,
  input logic [AW-1:0] fw_addr,
  input logic          fw_term_vld,
  input logic [1:0]    fw_term,
  input logic          serr_o,
  input logic [2:0]    sts_clr,
  input logic          sts_rx_tabort,
  input logic          sts_sig_tabort,
  input logic          sts_sig_serr
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ini_req |=> ini_rsp_vld);
  a_r1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ini_req |=> !ini_rsp_vld);
  a_r2_one_attempt: assert property (@(posedge clk) disable iff (!rst_n)
    fw_start |=> !fw_start);
  a_r3_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_term_vld && fw_term == 2'd1) |=> (!fw_start || $stable(fw_addr)));
  a_r5_abort_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_rsp_vld && ini_rsp == 2'd3) |-> sts_sig_tabort);
  a_r7_serr_status: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |=> sts_sig_serr);
  a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rx_tabort && !sts_clr[0]) |=> sts_rx_tabort);
  a_r9_sig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_sig_tabort && !sts_clr[1]) |=> sts_sig_tabort);
  a_r9_serr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_sig_serr && !sts_clr[2]) |=> sts_sig_serr);
endmodule

bind dwr_handler dwr_handler_chk #(.AW(AW)) u_chk (.*);

// File: tb/dwr_handler_tb.sv
module dwr_handler_tb;
  localparam int AW = 32, DW = 32, CW = 4, LD = 3, LM = 5;
  logic clk = 0, rst_n = 0;
  logic ini_req = 0, ini_multi = 0;
  logic [AW-1:0] ini_addr = 0;
  logic [CW-1:0] ini_cmd = 0;
  logic [DW/8-1:0] ini_be = 0;
  logic [DW-1:0] ini_data = 0;
  logic ini_rsp_vld, fw_start, serr_o, sts_rx_tabort, sts_sig_tabort, sts_sig_serr;
  logic [1:0] ini_rsp;
  logic [AW-1:0] fw_addr;
  logic [CW-1:0] fw_cmd;
  logic [DW/8-1:0] fw_be;
  logic [DW-1:0] fw_data;
  logic fw_term_vld = 0;
  logic [1:0] fw_term = 0;
  logic cfg_serr_en = 0, cfg_dwnd_dis = 0, cfg_lim_max = 0;
  logic [2:0] sts_clr = 0;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  dwr_handler #(.AW(AW), .DW(DW), .CW(CW), .LOG_DFLT(LD), .LOG_MAX(LM)) u_dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_rsp(logic [1:0] term, logic multi);
    if (term == 2'd3) return 2'd3;
    return multi ? 2'd2 : 2'd1;
  endfunction

  // drive a request at a negedge, return answer seen at the next negedge
  task automatic send(logic [AW-1:0] a, logic [CW-1:0] c, logic [DW/8-1:0] b,
                      logic [DW-1:0] d, logic m, output logic [1:0] rsp);
    ini_req = 1; ini_addr = a; ini_cmd = c; ini_be = b; ini_data = d; ini_multi = m;
    @(negedge clk);
    ini_req = 0;
    check("R1 rsp_vld", ini_rsp_vld, 1);
    rsp = ini_rsp;
  endtask

  task automatic term(logic [1:0] t);
    fw_term_vld = 1; fw_term = t;
    @(negedge clk);
    fw_term_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [1:0] r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R10 fw_start", fw_start, 0);
    check("R10 rsp_vld", ini_rsp_vld, 0);
    check("R10 status", {sts_rx_tabort, sts_sig_tabort, sts_sig_serr, serr_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle no rsp", ini_rsp_vld, 0);

    for (int it = 0; it < 60; it++) begin
      logic [AW-1:0] a = $urandom;
      logic [CW-1:0] c = CW'($urandom);
      logic [DW/8-1:0] b = (DW/8)'($urandom);
      logic [DW-1:0] d = $urandom;
      logic m = 1'($urandom);
      int nr = $urandom_range(0, 6);
      int np = $urandom_range(0, 2);
      logic [1:0] ft = 2'($urandom_range(0, 2));
      if (ft == 2'd1) ft = 2'd3;
      send(a, c, b, d, m, r);
      check("R1 first retry", r, 0);
      check("R1 start", fw_start, 1);
      check("R1 addr", fw_addr, a);
      check("R1 data", fw_data, d);
      for (int p = 0; p < np; p++) begin
        send(a, c, b, d, m, r);
        check("R2 pending retry", r, 0);
        check("R2 single start", fw_start, 0);
      end
      if (np == 0) @(negedge clk);
      for (int k = 0; k < nr; k++) begin
        term(2'd1);
        check("R3 reissue", fw_start, 1);
        check("R3 same addr", fw_addr, a);
        check("R3 same cmd/be/data", {fw_cmd, fw_be, fw_data}, {c, b, d});
        @(negedge clk);
      end
      term(ft);
      if (ft == 2'd3) check("R5 rx flag", sts_rx_tabort, 1);
      send(a, c, b, d ^ 32'h1, m, r);
      check("R6 mismatch retry", r, 0);
      send(a ^ 32'h4, c, b, d, m, r);
      check("R6 mismatch addr retry", r, 0);
      send(a, c, b, d, m, r);
      check(ft == 2'd3 ? "R5 abort rsp" : "R4 mapped rsp", r, exp_rsp(ft, m));
      if (ft == 2'd3) check("R5 sig flag", sts_sig_tabort, 1);
      check("R4 released", fw_start, 0);
      sts_clr = 3'b011;
      @(negedge clk);
      sts_clr = 0;
      check("R9 cleared", {sts_rx_tabort, sts_sig_tabort}, 0);
    end

    // sticky without clear
    send(32'h100, 4'h7, 4'hf, 32'hdead, 1, r);
    @(negedge clk);
    term(2'd3);
    repeat (3) @(negedge clk);
    check("R9 sticky", sts_rx_tabort, 1);
    send(32'h100, 4'h7, 4'hf, 32'hdead, 0, r);
    check("R5 abort single", r, 3);
    sts_clr = 3'b100;
    @(negedge clk);
    sts_clr = 0;
    check("R9 only selected bit", {sts_rx_tabort, sts_sig_tabort}, 2'b11);
    sts_clr = 3'b011;
    @(negedge clk);
    sts_clr = 0;

    // attempt limit, several enable/mask combos, both limits
    for (int cfg = 0; cfg < 5; cfg++) begin
      int lim;
      logic exp_s;
      cfg_serr_en = (cfg != 1);
      cfg_dwnd_dis = (cfg == 2);
      cfg_lim_max = (cfg >= 3);
      lim = cfg_lim_max ? (1 << LM) : (1 << LD);
      exp_s = cfg_serr_en && !cfg_dwnd_dis;
      send(32'h2000 + cfg, 4'h3, 4'h1, 32'h55, 0, r);
      @(negedge clk);
      for (int k = 0; k < lim - 1; k++) begin
        fw_term_vld = 1; fw_term = 1;
        #1 check("R7 no early serr", serr_o, 0);
        @(negedge clk);
        fw_term_vld = 0;
        check("R8 still attempting", fw_start, 1);
        @(negedge clk);
      end
      fw_term_vld = 1; fw_term = 1;
      #1 check("R7 serr gate", serr_o, exp_s);
      @(negedge clk);
      fw_term_vld = 0;
      check("R8 stop at limit", fw_start, 0);
      check("R7 serr status", sts_sig_serr, exp_s);
      if (cfg == 4) begin
        sts_clr = 3'b100;
        @(negedge clk);
        sts_clr = 0;
        check("R9 serr cleared", sts_sig_serr, 0);
      end
      send(32'h2000 + cfg, 4'h3, 4'h1, 32'h55, 0, r);
      check("R7 dropped entry relatched", r, 0);
      check("R7 new attempt", fw_start, 1);
      @(negedge clk);
      term(2'd0);
      send(32'h2000 + cfg, 4'h3, 4'h1, 32'h55, 0, r);
      check("R4 single complete", r, 1);
      if (cfg < 4) begin
        sts_clr = 3'b100;
        @(negedge clk);
        sts_clr = 0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule